// File: doc/BRIEF.md
# Command/Response Buffer Engine

This block carries one command and its response between a host and a processing backend. It uses a single shared byte buffer and one offset that serves both directions. The host sees two things: a byte-wide data port and a status word. It fills the buffer one byte per access. The engine watches a big-endian length field inside the command header to tell when the command is complete. A go write then hands the buffer to the backend as a start pulse plus a byte count.

The backend writes its response into the same buffer and pulses done. The host then drains the response byte by byte. Lifecycle commands are single-bit writes to the status word:

- become ready (or abort),
- go,
- replay the response.

The status word carries four flags, a sticky self-test bit, fixed family bits and a burst count. The burst count is the number of bytes left to read, or the free space left to write. Three one-cycle event outputs mark the moments a host interrupt layer would care about. An owner input states whether the requester currently holds the interface; accesses without it are ignored.

Top module: `cmd_resp_engine`

## Requirements
- R1: After reset the engine is idle. All four flags are clear, the self-test bit is clear, and the burst count equals BUF_BYTES. Flag positions in sts_word are: bit 0 command-ready, bit 1 valid, bit 2 data-available, bit 3 expect, bit 4 self-test-done. Bits 6:5 carry the FAMILY parameter and bits 23:8 carry the burst count.
- R2: A command-ready write has a different effect in each state:
  - in idle: move to ready, leaving only command-ready set, and pulse ev_cmd_ready;
  - in ready: only rewind the offset;
  - in completion: rewind the offset, move to ready leaving only command-ready set, and pulse ev_cmd_ready.
- R3: Data writes are dropped in idle, execution and completion. The first data write in ready moves to reception and leaves valid and expect set.
- R4: The command length is read from buffer bytes 2..5, most significant byte first. Once more than 5 bytes have been stored, expect clears when the stored count reaches that length, leaving only valid. A data write with expect set and the buffer full is dropped, and it clears expect.
- R5: A go write is acted on only in reception with expect clear. It moves to execution and pulses be_start one cycle later, with be_len equal to the number of bytes stored.
- R6: be_done in execution does four things: it rewinds the offset, enters completion, sets valid and data-available, and pulses ev_data_avail and ev_sts_valid. Backend buffer writes are accepted only in execution.
- R7: Reads in completion with data-available set return the response bytes in order. The last byte, at the clamped header length, clears data-available, keeps valid and pulses ev_sts_valid. Any other data-port read returns 0xFF and does not advance the offset.
- R8: A response-replay write in completion rewinds the offset and sets valid and data-available again.
- R9: The burst count is one of two values:
  - with data-available set: the clamped response length minus the offset, where the length is clamped to BUF_BYTES;
  - otherwise: BUF_BYTES minus the offset.

  With host_narrow high the burst count saturates at 255.
- R10: A status write takes effect only when exactly one of bit 0 (command-ready), bit 1 (go) or bit 2 (replay) is set. Bits 7:3 are ignored.
- R11: Status writes, data writes and data reads with host_owner low change nothing, and such reads return 0xFF.
- R12: Abort follows from a command-ready write:
  - in reception: return to ready at once, with only command-ready set and the offset rewound;
  - in execution: pulse be_cancel. The next be_done then enters ready with only command-ready set and pulses ev_cmd_ready instead of presenting a response.
- R13: The self-test bit is set by be_selftest together with be_done and is never cleared by flag updates. The family bits always equal FAMILY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_fifo | input | 1 | 1 = data port, 0 = status word |
| host_owner | input | 1 | Requester currently owns the interface |
| host_narrow | input | 1 | Byte-wide status view, saturates burst count |
| host_wdata | input | 8 | Write data byte or status command bits |
| host_rdata | output | 8 | Data port read byte |
| sts_word | output | 32 | Flags, self-test, family and burst count |
| ev_cmd_ready | output | 1 | Command-ready event pulse |
| ev_data_avail | output | 1 | Data-available event pulse |
| ev_sts_valid | output | 1 | Status-valid event pulse |
| be_start | output | 1 | Command handed to backend |
| be_len | output | $clog2(BUF_BYTES+1) | Command length in bytes |
| be_cancel | output | 1 | Cancel request to backend |
| be_wr_en | input | 1 | Backend response byte write |
| be_wr_addr | input | $clog2(BUF_BYTES) | Backend write address |
| be_wr_data | input | 8 | Backend write byte |
| be_done | input | 1 | Backend finished |
| be_selftest | input | 1 | Self-test passed, sampled with be_done |

## Verification
The bench builds the engine with BUF_BYTES = 300 and FAMILY = 2'b10. A 300-byte buffer is large enough that the free-space burst count exceeds 255, so narrow saturation is observable, and small enough that filling it to overflow with a header claiming 1000 bytes takes only a few hundred cycles. A response header larger than the buffer exercises the length clamp. Randomised command and response lengths between 6 and 40 bytes cover header completion at many offsets.

// File: rtl/cmd_resp_engine.sv
module cmd_resp_engine #(
  parameter int BUF_BYTES = 4096,
  parameter logic [1:0] FAMILY = 2'b01
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               host_en,
  input  logic                               host_wr,
  input  logic                               host_fifo,
  input  logic                               host_owner,
  input  logic                               host_narrow,
  input  logic [7:0]                         host_wdata,
  output logic [7:0]                         host_rdata,
  output logic [31:0]                        sts_word,
  output logic                               ev_cmd_ready,
  output logic                               ev_data_avail,
  output logic                               ev_sts_valid,
  output logic                               be_start,
  output logic [$clog2(BUF_BYTES+1)-1:0]     be_len,
  output logic                               be_cancel,
  input  logic                               be_wr_en,
  input  logic [$clog2(BUF_BYTES)-1:0]       be_wr_addr,
  input  logic [7:0]                         be_wr_data,
  input  logic                               be_done,
  input  logic                               be_selftest
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int LW = $clog2(BUF_BYTES+1);
  localparam logic [LW-1:0] FULL = LW'(BUF_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_READY, S_RECV, S_EXEC, S_DONE} st_t;

  st_t st;
  logic [7:0] mem [BUF_BYTES];
  logic [LW-1:0] off;
  logic f_rdy, f_val, f_dav, f_exp, f_self, abort_pend;
  logic [31:0] hdr;
  logic [LW-1:0] resp_len, burst_full;

  wire st_wr   = host_en & host_wr & ~host_fifo & host_owner;
  wire do_rdy  = st_wr && host_wdata[2:0] == 3'b001;
  wire do_go   = st_wr && host_wdata[2:0] == 3'b010;
  wire do_rpl  = st_wr && host_wdata[2:0] == 3'b100;
  wire fifo_wr = host_en & host_wr & host_fifo & host_owner;
  wire fifo_rd = host_en & ~host_wr & host_fifo & host_owner;
  wire room    = off < FULL;
  wire take    = fifo_wr && (st == S_READY || (st == S_RECV && f_exp)) && room;
  wire be_take = be_wr_en && st == S_EXEC;
  wire [LW-1:0] off_nxt = off + 1'b1;
  wire rd_ok   = fifo_rd && st == S_DONE && f_dav;
  wire rd_last = rd_ok && off_nxt >= resp_len;
  wire cmd_full = off_nxt > LW'(5) && hdr <= 32'(off_nxt);

  always_ff @(posedge clk)
    if (take) mem[off[AW-1:0]] <= host_wdata;
    else if (be_take) mem[be_wr_addr] <= be_wr_data;

  always_comb
    for (int i = 0; i < 4; i++)
      hdr[31-8*i -: 8] = (take && off == LW'(i+2)) ? host_wdata : mem[i+2];

  assign resp_len   = (hdr > 32'(BUF_BYTES)) ? FULL : hdr[LW-1:0];
  assign burst_full = f_dav ? resp_len - off : FULL - off;
  assign host_rdata = rd_ok ? mem[off[AW-1:0]] : 8'hFF;
  assign sts_word = {8'h00,
                     (host_narrow && burst_full > LW'(255)) ? 16'd255 : 16'(burst_full),
                     1'b0, FAMILY, f_self, f_exp, f_dav, f_val, f_rdy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; off <= '0; be_len <= '0;
      {f_rdy, f_val, f_dav, f_exp, f_self, abort_pend} <= '0;
      {ev_cmd_ready, ev_data_avail, ev_sts_valid, be_start, be_cancel} <= '0;
    end else begin
      {ev_cmd_ready, ev_data_avail, ev_sts_valid, be_start, be_cancel} <= '0;
      if (be_done && st == S_EXEC) begin
        if (be_selftest) f_self <= 1'b1;
        off <= '0;
        abort_pend <= 1'b0;
        if (abort_pend) begin
          st <= S_READY;
          {f_rdy, f_val, f_dav, f_exp} <= 4'b1000;
          ev_cmd_ready <= 1'b1;
        end else begin
          st <= S_DONE;
          {f_rdy, f_val, f_dav, f_exp} <= 4'b0110;
          ev_data_avail <= 1'b1;
          ev_sts_valid <= 1'b1;
        end
      end else if (do_rdy) begin
        case (st)
          S_READY: off <= '0;
          S_EXEC: begin
            be_cancel <= 1'b1;
            abort_pend <= 1'b1;
          end
          default: begin
            off <= '0;
            st <= S_READY;
            {f_rdy, f_val, f_dav, f_exp} <= 4'b1000;
            if (!(st == S_DONE && f_rdy)) ev_cmd_ready <= 1'b1;
          end
        endcase
      end else if (do_go && st == S_RECV && !f_exp) begin
        st <= S_EXEC;
        be_start <= 1'b1;
        be_len <= off;
      end else if (do_rpl && st == S_DONE) begin
        off <= '0;
        {f_rdy, f_val, f_dav, f_exp} <= 4'b0110;
      end else if (fifo_wr && (st == S_READY || st == S_RECV)) begin
        if (st == S_READY) st <= S_RECV;
        if (take) begin
          off <= off_nxt;
          {f_rdy, f_val, f_dav} <= 3'b010;
          f_exp <= !cmd_full;
        end else if (f_exp) begin
          {f_rdy, f_val, f_dav, f_exp} <= 4'b0100;
        end
      end else if (rd_ok) begin
        off <= off_nxt;
        if (rd_last) begin
          f_dav <= 1'b0;
          f_val <= 1'b1;
          ev_sts_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_resp_engine_chk.sv
module cmd_resp_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_en,
  input logic        host_wr,
  input logic        host_fifo,
  input logic        host_owner,
  input logic        host_narrow,
  input logic [7:0]  host_wdata,
  input logic [31:0] sts_word,
  input logic        ev_cmd_ready,
  input logic        ev_data_avail,
  input logic        be_start,
  input logic        be_done,
  input logic [2:0]  st,
  input logic        abort_pend
);
  p_start_after_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> $past(host_en && host_wr && !host_fifo && host_owner && host_wdata[2:0] == 3'b010));

  p_done_presents_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (be_done && st == 3'd3 && !abort_pend) |=> (sts_word[2] && ev_data_avail));

  p_dav_has_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_word[2] |-> sts_word[1]);

  p_expect_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sts_word[3] |-> (sts_word[1] && !sts_word[2] && !sts_word[0]));

  p_selftest_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sts_word[4] |=> sts_word[4]);

  p_narrow_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_narrow |-> sts_word[23:16] == 8'h00);

  p_nonowner_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_owner && !be_done) |=> $stable(sts_word[3:0]));

  p_event_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_cmd_ready && ev_data_avail));
endmodule

bind cmd_resp_engine cmd_resp_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_wr(host_wr),
  .host_fifo(host_fifo), .host_owner(host_owner), .host_narrow(host_narrow),
  .host_wdata(host_wdata), .sts_word(sts_word), .ev_cmd_ready(ev_cmd_ready),
  .ev_data_avail(ev_data_avail), .be_start(be_start), .be_done(be_done),
  .st(st), .abort_pend(abort_pend)
);

// File: tb/tb_cmd_resp_engine.sv
module tb_cmd_resp_engine;
  localparam int BUF = 300;
  localparam logic [1:0] FAM = 2'b10;
  localparam int AW = $clog2(BUF);
  localparam int LW = $clog2(BUF+1);

  logic clk = 0, rst_n = 0;
  logic host_en = 0, host_wr = 0, host_fifo = 0, host_owner = 0, host_narrow = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic [31:0] sts_word;
  logic ev_cmd_ready, ev_data_avail, ev_sts_valid, be_start, be_cancel;
  logic [LW-1:0] be_len;
  logic be_wr_en = 0, be_done = 0, be_selftest = 0;
  logic [AW-1:0] be_wr_addr = 0;
  logic [7:0] be_wr_data = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] rd_cap;
  logic [7:0] resp [BUF];

  always #10 clk = ~clk;

  cmd_resp_engine #(.BUF_BYTES(BUF), .FAMILY(FAM)) dut (.*);

  function automatic logic [31:0] flags(); return {28'h0, sts_word[3:0]}; endfunction
  function automatic logic [31:0] burst(); return {16'h0, sts_word[23:8]}; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic acc(input logic wr, fifo, owner, input logic [7:0] wd);
    host_en = 1; host_wr = wr; host_fifo = fifo; host_owner = owner; host_wdata = wd;
    #1 rd_cap = host_rdata;
    tick();
    host_en = 0; host_wr = 0; host_fifo = 0; host_owner = 0;
  endtask

  task automatic stw(input logic [7:0] v); acc(1, 0, 1, v); endtask
  task automatic fw(input logic [7:0] b); acc(1, 1, 1, b); endtask
  task automatic fr(); acc(0, 1, 1, 8'h00); endtask

  task automatic send_cmd(input int n, input logic [31:0] hl);
    for (int i = 0; i < n; i++)
      fw((i >= 2 && i <= 5) ? hl[8*(5-i) +: 8] : 8'($urandom));
  endtask

  task automatic respond(input int m, input logic [31:0] hl, input logic stp);
    for (int i = 0; i < m; i++) begin
      resp[i] = (i >= 2 && i <= 5) ? hl[8*(5-i) +: 8] : 8'($urandom);
      be_wr_en = 1; be_wr_addr = AW'(i); be_wr_data = resp[i];
      tick();
    end
    be_wr_en = 0;
    be_done = 1; be_selftest = stp;
    tick();
    be_done = 0; be_selftest = 0;
  endtask

  task automatic txn(input int n, input int m);
    stw(8'h01);
    chk("R2 ready flags", flags(), 32'h1);
    send_cmd(n, n);
    chk("R4 expect cleared at length", flags(), 32'h2);
    chk("R9 free space", burst(), BUF - n);
    stw(8'h02);
    chk("R5 be_start", be_start, 1);
    chk("R5 be_len", be_len, n);
    fw(8'h55);
    chk("R3 exec write dropped", burst(), BUF - n);
    respond(m, m, 0);
    chk("R6 flags", flags(), 32'h6);
    chk("R6 ev_data_avail", ev_data_avail, 1);
    chk("R6 ev_sts_valid", ev_sts_valid, 1);
    chk("R9 remaining", burst(), m);
    acc(0, 1, 0, 8'h00);
    chk("R11 nonowner read data", rd_cap, 8'hFF);
    chk("R11 nonowner read no advance", burst(), m);
    for (int i = 0; i < m; i++) begin
      fr();
      chk("R7 response byte", rd_cap, resp[i]);
    end
    chk("R7 last byte flags", flags(), 32'h2);
    chk("R7 last byte event", ev_sts_valid, 1);
    fr();
    chk("R7 read without data", rd_cap, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, m;
    void'($urandom(32'd20241));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 flags", flags(), 0);
    chk("R1 burst", burst(), BUF);
    chk("R13 family", {30'h0, sts_word[6:5]}, FAM);
    chk("R1 selftest", sts_word[4], 0);

    stw(8'h03);
    chk("R10 two bits ignored", flags(), 0);
    stw(8'hF8);
    chk("R10 upper bits ignored", flags(), 0);
    fw(8'h12);
    chk("R3 idle write dropped flags", flags(), 0);
    chk("R3 idle write dropped burst", burst(), BUF);
    acc(1, 0, 0, 8'h01);
    chk("R11 nonowner status write", flags(), 0);

    stw(8'h01);
    chk("R2 idle to ready", flags(), 32'h1);
    chk("R2 event", ev_cmd_ready, 1);
    stw(8'h01);
    chk("R2 ready rewind flags", flags(), 32'h1);
    chk("R2 ready no event", ev_cmd_ready, 0);
    host_narrow = 1;
    #1 chk("R9 narrow saturation", burst(), 255);
    host_narrow = 0;

    send_cmd(3, 32'd50);
    chk("R3 first write flags", flags(), 32'hA);
    chk("R9 free after 3", burst(), BUF - 3);
    stw(8'h02);
    chk("R5 go ignored with expect", be_start, 0);
    stw(8'h01);
    chk("R12 abort in reception flags", flags(), 32'h1);
    chk("R12 abort in reception offset", burst(), BUF);
    chk("R12 abort event", ev_cmd_ready, 1);

    for (int k = 0; k < 15; k++) begin
      n = 6 + int'($urandom % 35);
      m = 6 + int'($urandom % 35);
      txn(n, m);
    end

    stw(8'h04);
    chk("R8 replay flags", flags(), 32'h6);
    chk("R8 replay burst", burst(), m);
    fr();
    chk("R8 replay first byte", rd_cap, resp[0]);
    be_wr_en = 1; be_wr_addr = AW'(1); be_wr_data = ~resp[1];
    tick();
    be_wr_en = 0;
    fr();
    chk("R6 backend write outside execution ignored", rd_cap, resp[1]);
    stw(8'h01);
    chk("R2 completion to ready", flags(), 32'h1);
    chk("R2 completion event", ev_cmd_ready, 1);
    chk("R2 completion rewind", burst(), BUF);

    send_cmd(8, 8);
    stw(8'h02);
    stw(8'h01);
    chk("R12 cancel pulse", be_cancel, 1);
    respond(6, 6, 1);
    chk("R12 abort completes to ready", flags(), 32'h1);
    chk("R12 abort event", ev_cmd_ready, 1);
    chk("R13 selftest set", sts_word[4], 1);

    send_cmd(BUF, 32'd1000);
    chk("R4 full buffer still expecting", flags(), 32'hA);
    chk("R9 no free space", burst(), 0);
    fw(8'h77);
    chk("R4 overflow clears expect", flags(), 32'h2);
    stw(8'h02);
    chk("R5 full length", be_len, BUF);
    respond(8, 32'h0001_0000, 0);
    chk("R9 clamped remaining", burst(), BUF);
    host_narrow = 1;
    #1 chk("R9 narrow remaining", burst(), 255);
    host_narrow = 0;
    chk("R13 selftest sticky", sts_word[4], 1);
    chk("R13 family kept", {30'h0, sts_word[6:5]}, FAM);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule